// File: doc/BRIEF.md
# Link Self-Test Frame Checker

This block runs the built-in self test of a serial-link receiver. While a level-sensitive test enable is held high, every frame the link front end marks valid is descrambled and compared against the all-zeros test pattern sent by the far end. One status output reports the result. During the test it rests high and gives a half-clock low blip for each frame that carried at least one bad payload bit. When the enable is released, it freezes to a verdict: high for a clean run, steady low if anything failed. A saturating counter of errored frames can be read at any time.

The descrambler is self-synchronizing (x^23 + x^18 + 1), so it needs no seed from the transmitter. It is given a fixed number of frames after every lock acquisition before checking starts. If the link loses lock during a run, checking pauses and picks up again after the next settle period. Frame deserialization, clock recovery and clock-source selection sit upstream. A frame-valid strobe and a lock input stand in for them.

Top module: `link_bist_checker`

## Requirements
- R1: While reset is applied, and right after it, the pass output is low and the error count is zero.
- R2: On the first clock edge that samples the enable high, the error count is cleared and the pass output takes the value of the lock input. From the first edge in the window where lock is high, the pass output rests high.
- R3: The payload is frame bits 1 to 35. Bit 1 enters the descrambler first. Each descrambled bit is the received bit XOR the received bits 18 and 23 positions earlier in the stream. Any descrambled payload bit equal to 1 marks the frame as errored. Frame bit 0 is never checked.
- R4: After each lock acquisition inside a window, the first SETTLE_FRAMES valid frames (default 2) are not checked: they cause no pulse and no count.
- R5: For a checked errored frame sampled at a clock edge, the pass output is low during the low half of the following clock cycle and high during its high half.
- R6: Each checked errored frame adds one to the error count, which saturates at 2^CNT_W - 1. Pulses continue after the count saturates.
- R7: While lock is low inside a window, frames are not checked, no pulse appears and the count does not change. When lock returns, the settle period of R4 starts again.
- R8: On the edge that samples the enable low after a window, the pass output freezes: high in both clock phases if no frame was counted as errored in the window, low in both phases otherwise.
- R9: Outside a window, the pass output and the error count hold their values regardless of frames or lock, until a new window starts or reset is applied.
- R10: Frame data presented with frame-valid low is neither checked nor shifted into the descrambler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock (pixel clock or internal oscillator, chosen upstream) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Test window enable, level sensitive |
| link_lock | input | 1 | High while the receiver is locked |
| frm_valid | input | 1 | A frame is present on frm_data this cycle |
| frm_data | input | FRAME_W (36) | Received frame, payload in bits 1..35 |
| pass_o | output | 1 | Pass status: per-frame error blips during a window, held verdict after it |
| err_cnt | output | CNT_W (16) | Saturating count of errored frames in the current or last window |

## Verification
The bench goes after the settle period after lock and after relock. A design that checked from the first locked frame would count frames whose descrambler state is still foreign. Frames during a lock loss are also targeted: counting them would inflate the error rate. Garbage presented with frame-valid low is followed by a clean frame, so a descrambler that shifted on invalid cycles shows up as a false error. The bench also checks that a window after a failing one clears both the verdict and the count. It drives the counter into saturation, where a wrapping counter would read near zero. It checks the half-cycle blip in both clock phases, which catches a pulse on the wrong half or one stretched over the whole cycle.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;

   // phase of the test window
   typedef enum logic [1:0] {
      PH_HOLD   = 2'd0,   // no window: verdict is held
      PH_SETTLE = 2'd1,   // window open, descrambler settling after lock
      PH_CHECK  = 2'd2    // window open, frames are checked
   } bist_phase_e;

   function automatic int unsigned min1_clog2(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/bist_descrambler.sv
module bist_descrambler #(
   parameter int unsigned FRAME_W   = 36,
   parameter int unsigned PAY_LO    = 1,
   parameter int unsigned PAY_HI    = 35,
   parameter int unsigned LFSR_LEN  = 23,
   parameter int unsigned LFSR_TAP  = 18,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               err_o
);
   localparam int unsigned PAY_W = PAY_HI - PAY_LO + 1;

   initial begin
      assert (PAY_LO <= PAY_HI && PAY_HI < FRAME_W)
         else $error("payload field outside frame");
      assert (LFSR_TAP > 0 && LFSR_TAP < LFSR_LEN)
         else $error("tap must lie inside the shift register");
   end

   logic [PAY_W-1:0]    ord;      // ord[0] enters first
   logic [PAY_W-1:0]    plain;
   logic [LFSR_LEN-1:0] st_q;
   logic [LFSR_LEN-1:0] st_nxt;
   logic                unused_side;

   assign unused_side = ^frame_i;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign ord = frame_i[PAY_HI:PAY_LO];
      end else begin : g_msb_first
         for (genvar k = 0; k < PAY_W; k++) begin : g_rev
            assign ord[k] = frame_i[PAY_HI-k];
         end
      end
   endgenerate

   // unrolled self-synchronizing descrambler over the whole payload
   always_comb begin
      st_nxt = st_q;
      plain  = '0;
      for (int k = 0; k < PAY_W; k++) begin
         plain[k] = ord[k] ^ st_nxt[LFSR_TAP-1] ^ st_nxt[LFSR_LEN-1];
         st_nxt   = {st_nxt[LFSR_LEN-2:0], ord[k]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= '1;
      else if (shift_i) st_q <= st_nxt;
   end

   assign err_o = |plain;

   // R3: the newest history bit is the last payload bit received
   p_hist_newest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> st_q[0] == $past(ord[PAY_W-1]));
   // R10: invalid cycles leave the history alone
   p_hist_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(st_q));

endmodule

// File: rtl/bist_sat_counter.sv
module bist_sat_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] q_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("counter width out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q_o <= '0;
      else if (clr_i)                    q_o <= '0;
      else if (inc_i && q_o != CNT_MAX)  q_o <= q_o + 1'b1;
   end

   // R6: saturation holds the maximum
   p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && q_o == CNT_MAX) |=> q_o == CNT_MAX);
   // R6: one step per errored frame below the maximum
   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && q_o != CNT_MAX) |=> q_o == $past(q_o) + 1'b1);
   // R6: never moves without a cause
   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/bist_window_ctrl.sv
module bist_window_ctrl
   import link_bist_pkg::*;
#(
   parameter int unsigned SETTLE_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic lock_i,
   input  logic valid_i,
   input  logic err_raw_i,
   output logic start_o,
   output logic active_o,
   output logic hit_o,
   output logic fail_o,
   output logic err_q_o,
   output logic pass_lvl_o
);
   localparam int unsigned SET_W = min1_clog2(SETTLE_FRAMES);
   localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_FRAMES - 1);

   initial begin
      assert (SETTLE_FRAMES >= 1) else $error("settle period must be at least one frame");
   end

   bist_phase_e      phase_q;
   logic [SET_W-1:0] set_cnt_q;

   assign start_o  = (phase_q == PH_HOLD) && en_i;
   assign active_o = (phase_q != PH_HOLD);
   assign hit_o    = (phase_q == PH_CHECK) && en_i && lock_i && valid_i && err_raw_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_HOLD;
         set_cnt_q  <= '0;
         fail_o     <= 1'b0;
         err_q_o    <= 1'b0;
         pass_lvl_o <= 1'b0;
      end else begin
         err_q_o <= hit_o;
         if (phase_q == PH_HOLD) begin
            if (en_i) begin
               phase_q    <= PH_SETTLE;
               set_cnt_q  <= '0;
               fail_o     <= 1'b0;
               pass_lvl_o <= lock_i;
            end
         end else if (!en_i) begin
            phase_q    <= PH_HOLD;
            pass_lvl_o <= ~fail_o;
         end else begin
            if (lock_i) pass_lvl_o <= 1'b1;
            if (hit_o)  fail_o     <= 1'b1;
            if (!lock_i) begin
               phase_q   <= PH_SETTLE;
               set_cnt_q <= '0;
            end else if (phase_q == PH_SETTLE && valid_i) begin
               if (set_cnt_q == SET_LAST) phase_q   <= PH_CHECK;
               else                       set_cnt_q <= set_cnt_q + 1'b1;
            end
         end
      end
   end

   // R4: nothing is flagged while settling
   p_settle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SETTLE) |-> !hit_o);
   // R7: losing lock sends the window back to settling
   p_relock_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && en_i && !lock_i) |=> phase_q == PH_SETTLE);
   // R2: a fresh window forgets earlier failures
   p_fresh_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !fail_o);

endmodule

// File: rtl/link_bist_checker.sv
module link_bist_checker #(
   parameter int unsigned FRAME_W        = 36,
   parameter int unsigned PAY_LO         = 1,
   parameter int unsigned PAY_HI         = 35,
   parameter int unsigned LFSR_LEN       = 23,
   parameter int unsigned LFSR_TAP       = 18,
   parameter bit          LSB_FIRST      = 1'b1,
   parameter int unsigned SETTLE_FRAMES  = 2,
   parameter int unsigned CNT_W          = 16,
   parameter bit          HALF_CLK_PULSE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bist_en,
   input  logic               link_lock,
   input  logic               frm_valid,
   input  logic [FRAME_W-1:0] frm_data,
   output logic               pass_o,
   output logic [CNT_W-1:0]   err_cnt
);
   logic err_raw;
   logic start;
   logic active;
   logic hit;
   logic fail;
   logic err_q;
   logic pass_lvl;

   bist_descrambler #(
      .FRAME_W   (FRAME_W),
      .PAY_LO    (PAY_LO),
      .PAY_HI    (PAY_HI),
      .LFSR_LEN  (LFSR_LEN),
      .LFSR_TAP  (LFSR_TAP),
      .LSB_FIRST (LSB_FIRST)
   ) i_descr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (frm_valid),
      .frame_i (frm_data),
      .err_o   (err_raw)
   );

   bist_window_ctrl #(
      .SETTLE_FRAMES (SETTLE_FRAMES)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (bist_en),
      .lock_i     (link_lock),
      .valid_i    (frm_valid),
      .err_raw_i  (err_raw),
      .start_o    (start),
      .active_o   (active),
      .hit_o      (hit),
      .fail_o     (fail),
      .err_q_o    (err_q),
      .pass_lvl_o (pass_lvl)
   );

   bist_sat_counter #(
      .CNT_W (CNT_W)
   ) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start),
      .inc_i (hit),
      .q_o   (err_cnt)
   );

   generate
      if (HALF_CLK_PULSE) begin : g_half_pulse
         // blip only in the low half of the cycle after the errored frame
         assign pass_o = pass_lvl & ~(err_q & ~clk);
      end else begin : g_full_pulse
         assign pass_o = pass_lvl & ~err_q;
      end
   endgenerate

   // R2: count cleared when a window opens
   p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> err_cnt == '0);
   // R7: no blip for frames seen without lock
   p_no_blip_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !link_lock |=> !err_q);
   // R10: no blip for invalid cycles
   p_no_blip_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !err_q);
   // R8: verdict taken from the window's failure record
   p_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !bist_en) |=> pass_lvl == !$past(fail));
   // R9: held verdict and count outside a window
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !bist_en) |=> ($stable(pass_lvl) && $stable(err_cnt)));

endmodule

// File: tb/test_link_bist_checker.sv
module test_link_bist_checker;

   localparam int unsigned FW  = 36;
   localparam int unsigned CW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bist_en = 1'b0;
   logic          link_lock = 1'b0;
   logic          frm_valid = 1'b0;
   logic [FW-1:0] frm_data = '0;
   logic          pass_o;
   logic [CW-1:0] err_cnt;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [22:0] tx_s = 23'h5A5A5;
   bit side_t = 1'b0;

   always #4 clk = ~clk;

   link_bist_checker #(.CNT_W(CW), .SETTLE_FRAMES(2)) i_link_bist_checker (
      .clk       (clk),
      .rst_n     (rst_n),
      .bist_en   (bist_en),
      .link_lock (link_lock),
      .frm_valid (frm_valid),
      .frm_data  (frm_data),
      .pass_o    (pass_o),
      .err_cnt   (err_cnt)
   );

   // rows: {frames[3:0], error mask[11:0], expected count[3:0], expected verdict}
   localparam logic [20:0] VEC [5] = '{
      {4'd5,  12'h000, 4'd0,  1'b1},
      {4'd6,  12'h001, 4'd1,  1'b0},
      {4'd8,  12'h0A5, 4'd4,  1'b0},
      {4'd12, 12'hFFF, 4'd12, 1'b0},
      {4'd3,  12'h000, 4'd0,  1'b1}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // scrambled all-zeros frame; corruption flips payload bit 1 only
   task automatic mk_frame(input bit corrupt, output logic [FW-1:0] f);
      logic b;
      f = '0;
      for (int i = 1; i <= 35; i++) begin
         b    = tx_s[17] ^ tx_s[22];
         tx_s = {tx_s[21:0], b};
         f[i] = b;
      end
      f[0]   = side_t;   // R3: unchecked side bit toggles
      side_t = ~side_t;
      if (corrupt) f[1] = ~f[1];
   endtask

   task automatic send_frame(input bit corrupt, input bit lvl, input bit pulse, input string req);
      logic [FW-1:0] f;
      mk_frame(corrupt, f);
      @(negedge clk);
      frm_valid = 1'b1;
      frm_data  = f;
      @(posedge clk); #1;
      chk(32'(pass_o), 32'(lvl), {req, " pass high phase"});
      @(negedge clk);
      frm_valid = 1'b0;
      frm_data  = ~f;    // R10: junk while invalid
      #1;
      chk(32'(pass_o), 32'(lvl & ~pulse), {req, " pass low phase"});
   endtask

   task automatic start_window(input bit lock);
      @(negedge clk);
      bist_en   = 1'b1;
      link_lock = lock;
      @(posedge clk); #1;
      chk(32'(pass_o), 32'(lock), "R2 pass at window start");
      chk(32'(err_cnt), 0, "R2 count cleared at start");
   endtask

   task automatic end_window(input bit verdict, input string req);
      @(negedge clk);
      bist_en = 1'b0;
      @(posedge clk); #1;
      chk(32'(pass_o), 32'(verdict), {req, " verdict high phase"});
      @(negedge clk); #1;
      chk(32'(pass_o), 32'(verdict), {req, " verdict low phase"});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(32'(pass_o), 0, "R1 pass in reset");
      chk(32'(err_cnt), 0, "R1 count in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(32'(pass_o), 0, "R1 pass after reset");

      // table walk: R3, R5, R6, R8
      for (int r = 0; r < 5; r++) begin
         logic [20:0] v;
         v = VEC[r];
         start_window(1'b1);
         send_frame(1'b0, 1'b1, 1'b0, "R4 settle clean");
         send_frame(1'b0, 1'b1, 1'b0, "R4 settle clean");
         for (int k = 0; k < int'(v[20:17]); k++)
            send_frame(v[5+k], 1'b1, v[5+k], "R5 R3 table frame");
         chk(32'(err_cnt), 32'(v[4:1]), "R6 table count");
         end_window(v[0], "R8 table");
      end

      // R4: errored settle frames are ignored
      start_window(1'b1);
      send_frame(1'b1, 1'b1, 1'b0, "R4 settle errored");
      send_frame(1'b1, 1'b1, 1'b0, "R4 settle errored");
      chk(32'(err_cnt), 0, "R4 no count while settling");
      send_frame(1'b1, 1'b1, 1'b1, "R4 first checked frame");
      chk(32'(err_cnt), 1, "R4 count after settle");

      // R7: lock loss pauses checking, relock re-settles
      @(negedge clk);
      link_lock = 1'b0;
      send_frame(1'b1, 1'b1, 1'b0, "R7 unlocked frame");
      send_frame(1'b1, 1'b1, 1'b0, "R7 unlocked frame");
      chk(32'(err_cnt), 1, "R7 count frozen unlocked");
      @(negedge clk);
      link_lock = 1'b1;
      send_frame(1'b1, 1'b1, 1'b0, "R7 resettle frame");
      send_frame(1'b1, 1'b1, 1'b0, "R7 resettle frame");
      send_frame(1'b1, 1'b1, 1'b1, "R7 checked after relock");
      chk(32'(err_cnt), 2, "R7 count after relock");

      // R10: junk with valid low does nothing and leaves history intact
      @(negedge clk);
      frm_valid = 1'b0;
      frm_data  = '1;
      repeat (3) @(posedge clk);
      #1;
      chk(32'(pass_o), 1, "R10 invalid junk high phase");
      @(negedge clk); #1;
      chk(32'(pass_o), 1, "R10 invalid junk low phase");
      chk(32'(err_cnt), 2, "R10 count unchanged");
      send_frame(1'b0, 1'b1, 1'b0, "R10 clean frame after junk");

      // R6: saturation, blips continue
      for (int k = 0; k < 16; k++)
         send_frame(1'b1, 1'b1, 1'b1, "R6 saturating frame");
      chk(32'(err_cnt), 15, "R6 saturated count");
      end_window(1'b0, "R8 after saturation");

      // R9: held verdict ignores traffic
      send_frame(1'b1, 1'b0, 1'b0, "R9 held frame");
      send_frame(1'b0, 1'b0, 1'b0, "R9 held frame");
      @(negedge clk);
      link_lock = 1'b0;
      send_frame(1'b1, 1'b0, 1'b0, "R9 held unlocked");
      chk(32'(err_cnt), 15, "R9 count held");

      // R1: reset clears a held failure
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(32'(pass_o), 0, "R1 pass on reset");
      chk(32'(err_cnt), 0, "R1 count on reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R2: window opened without lock, pass rises with lock
      start_window(1'b0);
      @(negedge clk);
      link_lock = 1'b1;
      @(posedge clk); #1;
      chk(32'(pass_o), 1, "R2 pass rises at lock");
      send_frame(1'b0, 1'b1, 1'b0, "R4 settle clean");
      send_frame(1'b0, 1'b1, 1'b0, "R4 settle clean");
      send_frame(1'b0, 1'b1, 1'b0, "R3 clean checked");
      end_window(1'b1, "R8 clean window");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule